// File: doc/BRIEF.md
# AUX Request Framer

This block turns one DisplayPort AUX request into the byte stream that a lower transmit layer sends over the wire, then turns the reply that comes back into a completion report. A request carries a command nibble, a 20-bit address, a payload length and up to sixteen payload bytes, all presented in one beat. The framer builds a four-byte header from those fields and streams header and payload out one byte per cycle under a valid/ready handshake. Physical line coding, sync and preamble fields, and reply timeouts belong to other logic.

After the stream ends, the framer waits for a single reply beat made of a status byte, a returned byte count and the returned bytes. It reduces these to a completion code, the reply command nibble and a transferred byte count, and raises a one-cycle completion strobe. Only one request is handled at a time. The busy flag blocks further requests until the strobe.

Top module: `aux_req_framer`

## Requirements
- R1: Transmitted byte 0 is address bits 7:0, byte 1 is address bits 15:8, and byte 2 carries the full request command in bits 7:4 and address bits 19:16 in bits 3:0.
- R2: Header byte 3 bits 3:0 hold the payload length minus one, or 0 for a zero-length request.
- R3: Header byte 3 bits 7:4 hold 3 for a zero-length request. Otherwise they hold the low four bits of the transmit length, so a 16-byte write carries 4.
- R4: A write (command with bit 0 clear after bit 2 is cleared) sends the 4 header bytes followed by the payload, byte 0 first. A read (bit 0 set) sends only the 4 header bytes. `tx_last` marks the final byte.
- R5: A request longer than 16 bytes completes with code 4 (too big) and sends no byte. This check takes priority over R6.
- R6: After bit 2 (middle-of-transaction) is cleared, only commands 0x0, 0x1, 0x8 and 0x9 are legal. Any other command completes with code 5 (invalid) and sends no byte.
- R7: Reply status 0x01, 0x02 and 0x03 complete with codes 1 (timeout), 2 (flags) and 3 (error). In each case the reply command, count and data are all zero.
- R8: Any other status completes with code 0 (ok), and the reply command equals status bits 7:4.
- R9: A successful read reports min(returned count, buffer size, 16) as its count. It presents exactly that many returned bytes in `done_data`, byte i at bits 8i+7:8i, and zeros above them.
- R10: A successful write reports its payload length as the count, with `done_data` zero.
- R11: `req_ready` is the inverse of `busy`. `busy` rises on the cycle after acceptance, stays high through the completion strobe and falls on the cycle after it. Requests offered while busy are ignored.
- R12: While `tx_valid` is high and `tx_ready` is low, `tx_byte` and `tx_last` hold.
- R13: A reply beat offered before the last transmit byte has been taken is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Framer idle, request taken when valid |
| req_cmd | input | 4 | Request command nibble |
| req_addr | input | 20 | Request address |
| req_len | input | 6 | Payload length in bytes |
| req_buf_size | input | 6 | Requester buffer size for read data |
| req_payload | input | 128 | Write payload, byte i at bits 8i+7:8i |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit layer takes the byte |
| tx_byte | output | 8 | Transmit byte |
| tx_last | output | 1 | Final byte of the request |
| rsp_valid | input | 1 | Reply beat present |
| rsp_status | input | 8 | Reply status byte |
| rsp_count | input | 6 | Number of returned bytes |
| rsp_data | input | 128 | Returned bytes, byte i at bits 8i+7:8i |
| busy | output | 1 | Request in flight |
| done | output | 1 | One-cycle completion strobe |
| done_code | output | 3 | Completion code |
| done_cmd | output | 4 | Reply command nibble |
| done_count | output | 6 | Transferred byte count |
| done_data | output | 128 | Truncated read data |

## Verification
The bench builds the framer with the package defaults: a 16-byte payload ceiling and a 6-bit length field. The longest write then makes a 20-byte stream, which shows the transmit length wrapping to 4 in the header nibble. Lengths of 17 and above can be expressed, so the size reject is exercised. The returned count can exceed the buffer size, which lets the read truncation cut in both below and at the buffer size.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;

    localparam int MAX_PAY   = 16;
    localparam int HDR_BYTES = 4;
    localparam int LEN_W     = $clog2(MAX_PAY + 1) + 1;
    localparam int TOT_W     = $clog2(HDR_BYTES + MAX_PAY + 1);
    localparam int DATA_W    = MAX_PAY * 8;

    localparam logic [3:0] CMD_MOT_BIT = 4'h4;

    typedef enum logic [2:0] {
        CC_OK      = 3'd0,
        CC_TIMEOUT = 3'd1,
        CC_FLAGS   = 3'd2,
        CC_ERROR   = 3'd3,
        CC_TOO_BIG = 3'd4,
        CC_INVALID = 3'd5
    } cc_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEND,
        ST_WAIT,
        ST_DONE
    } st_e;

    typedef struct packed {
        cc_e               code;
        logic [3:0]        cmd;
        logic [LEN_W-1:0]  count;
        logic [DATA_W-1:0] data;
    } result_t;

    function automatic logic [3:0] cmd_base(input logic [3:0] cmd);
        return cmd & ~CMD_MOT_BIT;
    endfunction

    function automatic logic cmd_legal(input logic [3:0] cmd);
        logic [3:0] b;
        b = cmd_base(cmd);
        return (b == 4'h0) || (b == 4'h1) || (b == 4'h8) || (b == 4'h9);
    endfunction

    function automatic logic cmd_reads(input logic [3:0] cmd);
        return cmd[0];
    endfunction

endpackage

// File: rtl/aux_frm_hdr.sv
module aux_frm_hdr
    import aux_frm_pkg::*;
#(
    parameter int MAXP = MAX_PAY,
    parameter int LW   = LEN_W,
    parameter int TW   = TOT_W
) (
    input  logic [3:0]                  cmd,
    input  logic [19:0]                 addr,
    input  logic [LW-1:0]               len,
    output logic [HDR_BYTES-1:0][7:0]   hdr,
    output logic [TW-1:0]               total,
    output logic                        too_big,
    output logic                        legal,
    output logic                        rd
);

    logic [3:0] lo_nib;
    logic [3:0] hi_nib;

    always_comb begin
        too_big = (len > LW'(MAXP));
        legal   = cmd_legal(cmd);
        rd      = cmd_reads(cmd);

        if (rd) total = TW'(HDR_BYTES);
        else    total = TW'(HDR_BYTES) + TW'(len);

        // length field carries len-1; an empty request keeps it at zero
        lo_nib = (len == '0) ? 4'd0 : 4'(len - LW'(1));
        // bare-address requests advertise three; others the (wrapped) stream size
        hi_nib = (len == '0) ? 4'd3 : total[3:0];

        hdr[0] = addr[7:0];
        hdr[1] = addr[15:8];
        hdr[2] = {cmd, addr[19:16]};
        hdr[3] = {hi_nib, lo_nib};
    end

endmodule

// File: rtl/aux_frm_ser.sv
module aux_frm_ser
    import aux_frm_pkg::*;
#(
    parameter int MAXP = MAX_PAY,
    parameter int TW   = TOT_W
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      start,
    input  logic [HDR_BYTES-1:0][7:0] hdr_in,
    input  logic [MAXP*8-1:0]         pay_in,
    input  logic [TW-1:0]             total_in,
    input  logic                      tx_ready,
    output logic                      tx_valid,
    output logic [7:0]                tx_byte,
    output logic                      tx_last,
    output logic                      finished
);

    localparam int PW = $clog2(MAXP);

    logic [HDR_BYTES-1:0][7:0] hdr_q;
    logic [MAXP-1:0][7:0]      pay_q;
    logic [TW-1:0]             tot_q;
    logic [TW-1:0]             idx_q;
    logic                      act_q;
    logic [PW-1:0]             pidx;

    always_ff @(posedge clk) begin
        if (rst) begin
            hdr_q <= '0;
            pay_q <= '0;
            tot_q <= '0;
            idx_q <= '0;
            act_q <= 1'b0;
        end else if (start) begin
            hdr_q <= hdr_in;
            pay_q <= pay_in;
            tot_q <= total_in;
            idx_q <= '0;
            act_q <= 1'b1;
        end else if (act_q && tx_ready) begin
            if (tx_last) act_q <= 1'b0;
            else         idx_q <= idx_q + TW'(1);
        end
    end

    always_comb begin
        pidx     = PW'(idx_q - TW'(HDR_BYTES));
        tx_valid = act_q;
        tx_last  = act_q && (idx_q == tot_q - TW'(1));
        if (idx_q < TW'(HDR_BYTES)) tx_byte = hdr_q[idx_q[1:0]];
        else                        tx_byte = pay_q[pidx];
        finished = act_q && tx_ready && tx_last;
    end

endmodule

// File: rtl/aux_frm_rsp.sv
module aux_frm_rsp
    import aux_frm_pkg::*;
#(
    parameter int MAXP = MAX_PAY,
    parameter int LW   = LEN_W
) (
    input  logic [7:0]        status,
    input  logic [LW-1:0]     count_in,
    input  logic [MAXP*8-1:0] data_in,
    input  logic              rd,
    input  logic [LW-1:0]     req_len,
    input  logic [LW-1:0]     buf_size,
    output result_t           res
);

    logic [LW-1:0]     lim;
    logic [MAXP*8-1:0] kept;

    always_comb begin
        lim = count_in;
        if (buf_size < lim)   lim = buf_size;
        if (lim > LW'(MAXP))  lim = LW'(MAXP);
        for (int i = 0; i < MAXP; i++) begin
            kept[i*8 +: 8] = (LW'(i) < lim) ? data_in[i*8 +: 8] : 8'h00;
        end
    end

    always_comb begin
        res = '0;
        case (status)
            8'h01:   res.code = CC_TIMEOUT;
            8'h02:   res.code = CC_FLAGS;
            8'h03:   res.code = CC_ERROR;
            default: begin
                res.code = CC_OK;
                res.cmd  = status[7:4];
                if (rd) begin
                    res.count = lim;
                    res.data  = kept;
                end else begin
                    res.count = req_len;
                end
            end
        endcase
    end

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer
    import aux_frm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [3:0]         req_cmd,
    input  logic [19:0]        req_addr,
    input  logic [LEN_W-1:0]   req_len,
    input  logic [LEN_W-1:0]   req_buf_size,
    input  logic [DATA_W-1:0]  req_payload,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [7:0]         tx_byte,
    output logic               tx_last,
    input  logic               rsp_valid,
    input  logic [7:0]         rsp_status,
    input  logic [LEN_W-1:0]   rsp_count,
    input  logic [DATA_W-1:0]  rsp_data,
    output logic               busy,
    output logic               done,
    output logic [2:0]         done_code,
    output logic [3:0]         done_cmd,
    output logic [LEN_W-1:0]   done_count,
    output logic [DATA_W-1:0]  done_data
);

    st_e                       st_q;
    logic [LEN_W-1:0]          len_q;
    logic [LEN_W-1:0]          buf_q;
    logic                      rd_q;
    result_t                   res_q;

    logic [HDR_BYTES-1:0][7:0] hdr;
    logic [TOT_W-1:0]          total;
    logic                      too_big;
    logic                      legal;
    logic                      rd;
    logic                      accept;
    logic                      start;
    logic                      fin;
    result_t                   dec_res;

    aux_frm_hdr #(.MAXP(MAX_PAY), .LW(LEN_W), .TW(TOT_W)) u_hdr (
        .cmd     (req_cmd),
        .addr    (req_addr),
        .len     (req_len),
        .hdr     (hdr),
        .total   (total),
        .too_big (too_big),
        .legal   (legal),
        .rd      (rd)
    );

    assign accept = (st_q == ST_IDLE) && req_valid;
    assign start  = accept && !too_big && legal;

    aux_frm_ser #(.MAXP(MAX_PAY), .TW(TOT_W)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .hdr_in   (hdr),
        .pay_in   (req_payload),
        .total_in (total),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .tx_last  (tx_last),
        .finished (fin)
    );

    aux_frm_rsp #(.MAXP(MAX_PAY), .LW(LEN_W)) u_rsp (
        .status   (rsp_status),
        .count_in (rsp_count),
        .data_in  (rsp_data),
        .rd       (rd_q),
        .req_len  (len_q),
        .buf_size (buf_q),
        .res      (dec_res)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            len_q <= '0;
            buf_q <= '0;
            rd_q  <= 1'b0;
            res_q <= '0;
        end else begin
            case (st_q)
                ST_IDLE: if (accept) begin
                    len_q <= req_len;
                    buf_q <= req_buf_size;
                    rd_q  <= rd;
                    if (too_big) begin
                        res_q      <= '0;
                        res_q.code <= CC_TOO_BIG;
                        st_q       <= ST_DONE;
                    end else if (!legal) begin
                        res_q      <= '0;
                        res_q.code <= CC_INVALID;
                        st_q       <= ST_DONE;
                    end else begin
                        st_q <= ST_SEND;
                    end
                end
                ST_SEND: if (fin) st_q <= ST_WAIT;
                ST_WAIT: if (rsp_valid) begin
                    res_q <= dec_res;
                    st_q  <= ST_DONE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready  = (st_q == ST_IDLE);
    assign busy       = (st_q != ST_IDLE);
    assign done       = (st_q == ST_DONE);
    assign done_code  = res_q.code;
    assign done_cmd   = res_q.cmd;
    assign done_count = res_q.count;
    assign done_data  = res_q.data;

endmodule

// File: rtl/aux_frm_chk.sv
module aux_frm_chk
    import aux_frm_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [3:0]       req_cmd,
    input logic [LEN_W-1:0] req_len,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic [7:0]       tx_byte,
    input logic             tx_last,
    input logic             busy,
    input logic             done,
    input logic [2:0]       done_code,
    input logic [3:0]       done_cmd,
    input logic [LEN_W-1:0] done_count
);

    logic [3:0] base;
    logic       ok_cmd;
    assign base   = req_cmd & 4'hB;
    assign ok_cmd = (base == 4'h0) || (base == 4'h1) || (base == 4'h8) || (base == 4'h9);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> busy);

    // R11
    strobe_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);

    // R11
    strobe_release_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy && req_ready);

    // R4
    tx_in_flight_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> busy && !done && !req_ready);

    // R12
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte) && $stable(tx_last));

    // R5
    oversize_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_len > LEN_W'(MAX_PAY))
        |=> done && !tx_valid && (done_code == 3'd4));

    // R6
    bad_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready && (req_len <= LEN_W'(MAX_PAY)) && !ok_cmd
        |=> done && !tx_valid && (done_code == 3'd5));

    // R7
    fail_empty_chk: assert property (@(posedge clk) disable iff (rst)
        done && (done_code != 3'd0) |-> (done_count == '0) && (done_cmd == 4'd0));

endmodule

bind aux_req_framer aux_frm_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_cmd    (req_cmd),
    .req_len    (req_len),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .tx_byte    (tx_byte),
    .tx_last    (tx_last),
    .busy       (busy),
    .done       (done),
    .done_code  (done_code),
    .done_cmd   (done_cmd),
    .done_count (done_count)
);

// File: tb/aux_req_framer_test.sv
`timescale 1ns/1ps
module aux_req_framer_test;

    logic         clk = 0;
    logic         rst = 1;
    logic         req_valid = 0;
    logic         req_ready;
    logic [3:0]   req_cmd = 0;
    logic [19:0]  req_addr = 0;
    logic [5:0]   req_len = 0;
    logic [5:0]   req_buf_size = 0;
    logic [127:0] req_payload = 0;
    logic         tx_valid;
    logic         tx_ready = 0;
    logic [7:0]   tx_byte;
    logic         tx_last;
    logic         rsp_valid = 0;
    logic [7:0]   rsp_status = 0;
    logic [5:0]   rsp_count = 0;
    logic [127:0] rsp_data = 0;
    logic         busy;
    logic         done;
    logic [2:0]   done_code;
    logic [3:0]   done_cmd;
    logic [5:0]   done_count;
    logic [127:0] done_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [7:0] got [0:31];
    int n_got;

    always #2.5 clk = ~clk;

    aux_req_framer uut (.*);

    task automatic chk(input string r, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        finish_run();
    end

    task automatic send_req(input logic [3:0] c, input logic [19:0] a, input logic [5:0] l,
                            input logic [5:0] b, input logic [127:0] p);
        req_valid = 1; req_cmd = c; req_addr = a; req_len = l; req_buf_size = b; req_payload = p;
        @(negedge clk);
        req_valid = 0;
        chk("R11 busy after accept", busy, 1);
    endtask

    task automatic collect(input bit stall, input bit noise);
        int guard = 0;
        bit fin = 0;
        bit hv = 0;
        logic [7:0] held = 0;
        n_got = 0;
        while (!fin && guard < 500) begin
            tx_ready  = stall ? ((guard % 3) != 1) : 1'b1;
            rsp_valid = noise;
            rsp_status = 8'h03;
            if (hv) begin
                chk("R12 held byte", tx_byte, held);
                hv = 0;
            end
            if (tx_valid && !tx_ready) begin held = tx_byte; hv = 1; end
            if (tx_valid && tx_ready) begin
                got[n_got] = tx_byte;
                n_got++;
                if (tx_last) fin = 1;
            end
            @(negedge clk);
            guard++;
        end
        tx_ready = 0; rsp_valid = 0;
    endtask

    task automatic cmp_stream(input string r, input int exp_n, input logic [159:0] exp);
        chk({r, " length"}, n_got, exp_n);
        for (int i = 0; i < exp_n && i < n_got; i++)
            chk(r, got[i], exp[i*8 +: 8]);
    endtask

    task automatic reply(input string r, input logic [7:0] st, input logic [5:0] cnt,
                         input logic [127:0] d, input logic [2:0] ec, input logic [3:0] ecmd,
                         input logic [5:0] ecnt, input logic [127:0] ed);
        rsp_valid = 1; rsp_status = st; rsp_count = cnt; rsp_data = d;
        @(negedge clk);
        rsp_valid = 0;
        chk({r, " R11 strobe"}, done, 1);
        chk({r, " code"}, done_code, ec);
        chk({r, " cmd"}, done_cmd, ecmd);
        chk({r, " count"}, done_count, ecnt);
        chk({r, " data"}, done_data, ed);
        @(negedge clk);
        chk("R11 released", {busy, req_ready, done}, 3'b010);
    endtask

    task automatic t_reset();
        chk("R11 reset busy", busy, 0);
        chk("R11 reset ready", req_ready, 1);
        chk("R11 reset tx/done", {tx_valid, done}, 0);
    endtask

    task automatic t_native_write();
        send_req(4'h8, 20'h5A3C1, 6'd3, 6'd0, 128'h33_22_11);
        collect(0, 0);
        cmp_stream("R1 R2 R3 R4 write", 7, 160'h33_22_11_72_85_A3_C1);
        reply("R8 R10 write ok", 8'h00, 6'd5, 128'hDEAD, 3'd0, 4'h0, 6'd3, 128'h0);
    endtask

    task automatic t_i2c_read_trunc();
        send_req(4'h5, 20'h00050, 6'd4, 6'd2, 128'hFFFF);
        collect(0, 0);
        cmp_stream("R1 R2 R4 read", 4, 160'h43_50_00_50);
        // requests while waiting are ignored (R11)
        req_valid = 1; req_cmd = 4'h8; req_len = 6'd5;
        repeat (2) begin
            @(negedge clk);
            chk("R11 ignored while busy", {req_ready, tx_valid}, 2'b00);
        end
        req_valid = 0;
        reply("R9 R8 read trunc", 8'h10, 6'd4, 128'hDD_CC_BB_AA, 3'd0, 4'h1, 6'd2, 128'hBB_AA);
    endtask

    task automatic t_bare_write();
        send_req(4'h0, 20'hF0012, 6'd0, 6'd0, 128'h77);
        collect(0, 0);
        cmp_stream("R3 R2 bare write", 4, 160'h30_0F_00_12);
        reply("R8 R10 bare", 8'h20, 6'd0, 128'h0, 3'd0, 4'h2, 6'd0, 128'h0);
    endtask

    task automatic t_full_write_stall();
        logic [127:0] p = 0;
        logic [159:0] e = 0;
        for (int i = 0; i < 16; i++) p[i*8 +: 8] = 8'(i * 7 + 1);
        e[31:0] = 32'h4F_80_01_00;
        e[159:32] = p;
        send_req(4'h8, 20'h00100, 6'd16, 6'd0, p);
        collect(1, 0);
        cmp_stream("R3 R4 R12 full write", 20, e);
        reply("R7 flags", 8'h02, 6'd3, 128'h1234, 3'd2, 4'h0, 6'd0, 128'h0);
    endtask

    task automatic t_bare_read_timeout();
        send_req(4'h9, 20'hFFFFF, 6'd0, 6'd8, 128'h0);
        collect(0, 0);
        cmp_stream("R3 R4 bare read", 4, 160'h30_9F_FF_FF);
        reply("R7 timeout", 8'h01, 6'd4, 128'hAAAA, 3'd1, 4'h0, 6'd0, 128'h0);
    endtask

    task automatic t_read_noise();
        logic [127:0] d = 0;
        logic [127:0] e = 0;
        for (int i = 0; i < 16; i++) d[i*8 +: 8] = 8'(8'h40 + i);
        for (int i = 0; i < 10; i++) e[i*8 +: 8] = 8'(8'h40 + i);
        send_req(4'h9, 20'h12345, 6'd8, 6'd16, 128'h0);
        collect(1, 1);
        cmp_stream("R13 R2 read under noise", 4, 160'h47_91_23_45);
        chk("R13 no early strobe", done, 0);
        reply("R9 R13 read count", 8'h00, 6'd10, d, 3'd0, 4'h0, 6'd10, e);
    endtask

    task automatic t_read_error();
        send_req(4'h1, 20'h00000, 6'd1, 6'd4, 128'h0);
        collect(0, 0);
        cmp_stream("R2 R3 one-byte read", 4, 160'h40_10_00_00);
        reply("R7 error", 8'h03, 6'd2, 128'hBEEF, 3'd3, 4'h0, 6'd0, 128'h0);
    endtask

    task automatic t_reject(input string r, input logic [3:0] c, input logic [5:0] l,
                            input logic [2:0] ec);
        req_valid = 1; req_cmd = c; req_addr = 20'h0ABCD; req_len = l;
        @(negedge clk);
        req_valid = 0;
        chk({r, " strobe"}, done, 1);
        chk({r, " code"}, done_code, ec);
        chk({r, " no tx"}, tx_valid, 0);
        chk({r, " count"}, done_count, 0);
        @(negedge clk);
        chk({r, " R11 released"}, {busy, tx_valid}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        t_native_write();
        t_i2c_read_trunc();
        t_bare_write();
        t_full_write_stall();
        t_bare_read_timeout();
        t_read_noise();
        t_read_error();
        t_reject("R5 len 17", 4'h8, 6'd17, 3'd4);
        t_reject("R5 beats R6", 4'hA, 6'd40, 3'd4);
        t_reject("R6 cmd A", 4'hA, 6'd2, 3'd5);
        t_reject("R6 cmd 2", 4'h2, 6'd0, 3'd5);
        t_reject("R6 cmd E", 4'hE, 6'd1, 3'd5);
        finish_run();
    end

endmodule